// File: doc/BRIEF.md
# Contact Image Sensor Line Timing and Bi-level Capture

This block drives a monochrome contact image sensor one scan line at a time. It does four things:

- It repeats a line period of fixed length.
- It raises a shift-gate pulse at the start of every line.
- It runs a continuous square-wave pixel clock.
- It walks through a burst of pixel slots, one pixel per pixel-clock period.

At the end of each pixel slot the block takes the 8-bit digitized video sample and compares it with a programmable threshold. A sample below the threshold counts as black (1); any other sample counts as white (0). The bits are packed into bytes, most significant bit first. Each finished byte leaves through a single-cycle write strobe with an address and data, so an image line buffer in RAM can store it for later coding or printing.

All timing comes from parameters counted in system clock cycles: the pixel period, the line period and the number of pixels per line. The defaults give 1728 pixels per line, a pixel period of about 1.98 µs and a line period of about 5 ms at a 32.26 MHz clock. After the last pixel, a one-cycle line-done flag marks the finished line. The block then stays quiet until the next line boundary. Dropping the enable abandons the current line at once.

Top module: `cis_line_timer`

## Requirements
- R1: While reset is high, and in the cycle after it, the outputs sg_o, pix_clk_o, pix_valid_o, wr_en_o and line_done_o are all 0.
- R2: With the block enabled, a line lasts LINE_CLKS clocks. sg_o is 1 during the first PIX_CLKS clocks of each line, and 0 for the rest of the line.
- R3: While the block is enabled, pix_clk_o repeats every PIX_CLKS clocks and restarts at each line boundary. It is 1 for the first PIX_CLKS/2 clocks of each period.
- R4: pix_valid_o pulses for one cycle exactly PIXELS times per line. Each pulse falls in the last clock of pixel periods 1 through PIXELS (period 0 holds the shift gate).
- R5: A pixel is coded 1 (black) when its video sample is strictly below threshold_i, and 0 (white) otherwise. Video and threshold are both taken in the cycle of the pixel's strobe.
- R6: Eight consecutive pixels form one byte. The first of the eight lands in bit 7 and the eighth in bit 0.
- R7: A byte write (wr_en_o high for one cycle) falls in the same cycle as the strobe of the byte's eighth pixel. Addresses run from 0 up to PIXELS/8-1 within a line and start again at 0 on every line.
- R8: line_done_o is high for exactly one cycle per completed line, in the same cycle as the line's final byte write.
- R9: When enable_i is low, every output strobe and sg_o and pix_clk_o are 0 in the next cycle. A partly built byte is discarded and no line_done_o is raised for the abandoned line. A new line starts from its shift gate once enable_i returns.
- R10: From after the last pixel of a line until the next line boundary, no pixel strobe, byte write or line-done is produced. The pixel clock keeps running during this time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Runs line timing while high; low abandons the line |
| threshold_i | input | 8 | Black/white decision level |
| video_i | input | 8 | Digitized sensor sample |
| sg_o | output | 1 | Shift-gate (line start) pulse to the sensor |
| pix_clk_o | output | 1 | Sensor pixel clock |
| pix_valid_o | output | 1 | One-cycle strobe per captured pixel |
| wr_en_o | output | 1 | Byte write strobe to the line buffer |
| wr_addr_o | output | ADDR_W | Byte address within the line |
| wr_data_o | output | 8 | Packed pixel byte, first pixel in bit 7 |
| line_done_o | output | 1 | One-cycle flag after the final pixel of a line |

## Verification
The final pixel of a line does three things in one cycle: it completes the last byte, it starts that byte's write, and it raises line-done. A wrong order or an off-by-one here would split these events or drop one of them. The bench lets several complete lines run, and a reference model compares the write, the address, the data and line-done on every clock. It also counts line-done pulses over a known interval. Abandoning a line mid-burst then shows the other side of the same timing: the partial byte must never be written, and line-done must stay low.

// File: rtl/cis_pkg.sv
package cis_pkg;

  // Pixel event produced by the sequencer for the packer.
  typedef struct packed {
    logic smp;   // last clock of a pixel slot inside the burst
    logic last;  // this sample is the final pixel of the line
  } pix_evt_t;

  // Counter width that never collapses to zero bits.
  function automatic int unsigned wmin1(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cis_line_seq.sv
module cis_line_seq
  import cis_pkg::*;
#(
  parameter int unsigned PIXELS    = 1728,
  parameter int unsigned PIX_CLKS  = 64,
  parameter int unsigned LINE_CLKS = 161290
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  output logic     sg_o,
  output logic     pclk_o,
  output pix_evt_t evt
);

  localparam int unsigned LC_W = wmin1(LINE_CLKS);
  localparam int unsigned PC_W = wmin1(PIX_CLKS);
  localparam int unsigned SL_W = wmin1(PIXELS + 2);
  localparam int unsigned HALF = PIX_CLKS / 2;

  logic [LC_W-1:0] lc;
  logic [PC_W-1:0] pc;
  logic [SL_W-1:0] slot;

  logic line_wrap, pix_wrap, in_burst;

  assign line_wrap = (lc == LC_W'(LINE_CLKS - 1));
  assign pix_wrap  = (pc == PC_W'(PIX_CLKS - 1));
  assign in_burst  = (slot != '0) && (slot <= SL_W'(PIXELS));

  // Line position, pixel phase and slot index (slot 0 = shift gate).
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      lc   <= '0;
      pc   <= '0;
      slot <= '0;
    end else if (line_wrap) begin
      lc   <= '0;
      pc   <= '0;
      slot <= '0;
    end else begin
      lc <= lc + 1'b1;
      if (pix_wrap) begin
        pc <= '0;
        if (slot != SL_W'(PIXELS + 1)) slot <= slot + 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  always_comb begin
    evt.smp  = enable && pix_wrap && in_burst;
    evt.last = enable && pix_wrap && (slot == SL_W'(PIXELS));
  end

  // Registered sensor clocks.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      sg_o   <= 1'b0;
      pclk_o <= 1'b0;
    end else begin
      sg_o   <= (slot == '0);
      pclk_o <= (pc < PC_W'(HALF));
    end
  end

  // R2
  sg_no_sample_chk: assert property (@(posedge clk) disable iff (rst)
    sg_o |-> !evt.smp);

endmodule

// File: rtl/cis_bin_pack.sv
module cis_bin_pack
  import cis_pkg::*;
#(
  parameter int unsigned PIXELS = 1728,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  pix_evt_t          evt,
  input  logic [7:0]        video,
  input  logic [7:0]        thr,
  output logic              pix_valid_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              line_done_o
);

  localparam int unsigned BYTES = PIXELS / 8;

  logic [6:0]        sh;
  logic [2:0]        bc;
  logic [ADDR_W-1:0] bi;
  logic              blk;

  assign blk = (video < thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      bc          <= '0;
      bi          <= '0;
      pix_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      line_done_o <= 1'b0;
    end else if (!enable) begin
      sh          <= '0;
      bc          <= '0;
      bi          <= '0;
      pix_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
      line_done_o <= 1'b0;
    end else begin
      pix_valid_o <= evt.smp;
      line_done_o <= evt.last;
      wr_en_o     <= 1'b0;
      if (evt.smp) begin
        sh <= {sh[5:0], blk};
        bc <= bc + 1'b1;
        if (bc == 3'd7) begin
          wr_en_o   <= 1'b1;
          wr_data_o <= {sh, blk};
          wr_addr_o <= bi;
          bi        <= evt.last ? '0 : bi + 1'b1;
        end
      end
    end
  end

  // R4
  pix_single_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |=> !pix_valid_o);

  // R7
  wr_with_pix_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> pix_valid_o);

  // R8
  done_last_byte_chk: assert property (@(posedge clk) disable iff (rst)
    line_done_o |-> (wr_en_o && (wr_addr_o == ADDR_W'(BYTES - 1))));

endmodule

// File: rtl/cis_line_timer.sv
module cis_line_timer
  import cis_pkg::*;
#(
  parameter int unsigned PIXELS    = 1728,
  parameter int unsigned PIX_CLKS  = 64,
  parameter int unsigned LINE_CLKS = 161290,
  localparam int unsigned ADDR_W   = wmin1(PIXELS / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [7:0]        threshold_i,
  input  logic [7:0]        video_i,
  output logic              sg_o,
  output logic              pix_clk_o,
  output logic              pix_valid_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              line_done_o
);

  pix_evt_t evt;

  cis_line_seq #(
    .PIXELS   (PIXELS),
    .PIX_CLKS (PIX_CLKS),
    .LINE_CLKS(LINE_CLKS)
  ) seq_i (
    .clk   (clk),
    .rst   (rst),
    .enable(enable_i),
    .sg_o  (sg_o),
    .pclk_o(pix_clk_o),
    .evt   (evt)
  );

  cis_bin_pack #(
    .PIXELS(PIXELS),
    .ADDR_W(ADDR_W)
  ) pack_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable_i),
    .evt        (evt),
    .video      (video_i),
    .thr        (threshold_i),
    .pix_valid_o(pix_valid_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .line_done_o(line_done_o)
  );

  // R9
  abandon_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!pix_valid_o && !wr_en_o && !line_done_o && !sg_o && !pix_clk_o));

endmodule

// File: tb/cis_line_timer_tb_top.sv
module cis_line_timer_tb_top;

  localparam int N = 16;
  localparam int P = 4;
  localparam int L = 100;
  localparam int AW = (N / 8 < 2) ? 1 : $clog2(N / 8);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] thr = 8'd128;
  logic [7:0] video = 8'd0;
  logic sg, pclk, pv, wr, done;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;

  always #2 clk = ~clk;

  cis_line_timer #(.PIXELS(N), .PIX_CLKS(P), .LINE_CLKS(L)) dut_i (
    .clk(clk), .rst(rst), .enable_i(en), .threshold_i(thr), .video_i(video),
    .sg_o(sg), .pix_clk_o(pclk), .pix_valid_o(pv), .wr_en_o(wr),
    .wr_addr_o(waddr), .wr_data_o(wdata), .line_done_o(done)
  );

  int ncmp = 0;
  int nerr = 0;
  int cyc  = 0;
  int vmode = 0;
  int done_cnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: time in line, pixel list, byte queue.
  int tl = 0, nbits = 0, nbyte = 0, sh = 0;
  int e_sg = 0, e_pclk = 0, e_pv = 0, e_wr = 0, e_done = 0, e_data = 0, e_addr = 0;

  always @(posedge clk) begin
    int slot, ph, b;
    if (rst || !en) begin
      tl = 0; nbits = 0; nbyte = 0; sh = 0;
      e_sg = 0; e_pclk = 0; e_pv = 0; e_wr = 0; e_done = 0;
    end else begin
      slot = tl / P;
      ph   = tl % P;
      e_sg   = (slot == 0) ? 1 : 0;
      e_pclk = (ph < P / 2) ? 1 : 0;
      e_pv = 0; e_wr = 0; e_done = 0;
      if (ph == P - 1 && slot >= 1 && slot <= N) begin
        e_pv = 1;
        b = (int'(video) < int'(thr)) ? 1 : 0;
        sh = ((sh << 1) | b) & 255;
        nbits++;
        if (nbits == 8) begin
          e_wr = 1; e_data = sh; e_addr = nbyte;
          nbyte++; nbits = 0;
        end
        if (slot == N) begin
          e_done = 1;
          nbyte = 0;
        end
      end
      tl = (tl == L - 1) ? 0 : tl + 1;
    end
  end

  // Per-clock comparison, video pattern and watchdog.
  always @(negedge clk) begin
    cyc++;
    chk("R2 sg", int'(sg), e_sg);
    chk("R3 pix_clk", int'(pclk), e_pclk);
    chk("R4 pix_valid", int'(pv), e_pv);
    chk("R7 wr_en", int'(wr), e_wr);
    chk("R8 line_done", int'(done), e_done);
    if (e_wr == 1) begin
      chk("R5/R6 wr_data", int'(wdata), e_data);
      chk("R7 wr_addr", int'(waddr), e_addr);
    end
    if (done === 1'b1) done_cnt++;
    case (vmode)
      0: video <= 8'((cyc * 73 + 11) & 255);
      1: video <= 8'd255;
      2: video <= 8'd254;
      3: video <= thr;
      default: video <= (cyc % 2 == 0) ? 8'd0 : 8'd200;
    endcase
    if (cyc > 200000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected below 200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4);
    // R1: outputs quiet during reset
    chk("R1 reset", int'({sg, pclk, pv, wr, done}), 0);
    rst = 1'b0;
    run(1);
    chk("R1 after reset", int'({sg, pclk, pv, wr, done}), 0);
    // Three full lines, mixed video (R2..R8, R10)
    en = 1'b1; thr = 8'd128; vmode = 0;
    done_cnt = 0;
    run(300);
    chk("R8 lines completed", done_cnt, 3);
    // R9: abandon mid-burst
    run(40);
    en = 1'b0;
    run(5);
    chk("R9 no done on abandon", done_cnt, 3);
    en = 1'b1;
    run(250);
    // R5: threshold zero gives all white
    thr = 8'd0;
    run(200);
    // R5: 255 against 255 is white, 254 is black
    thr = 8'd255; vmode = 1;
    run(100);
    vmode = 2;
    run(100);
    // R5: sample equal to threshold is white
    thr = 8'd100; vmode = 3;
    run(100);
    // R6: alternating pixels expose bit order
    thr = 8'd128; vmode = 4;
    run(200);
    // R9: short drop then immediate restart
    en = 1'b0;
    run(1);
    en = 1'b1;
    run(150);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

endmodule